// File: doc/BRIEF.md
# Clock-movement coil step driver

This block steps the two-terminal coil of an analogue clock movement. A periodic tick strobe, nominally 32 per second, advances an 8-bit tick counter. When the counter reaches the threshold of the current rate, the block issues one step. At the normal rate the threshold is 32 ticks, which gives one step per second. Two active-low mode switches can instead select one of three programmable divider values, which makes the hands run faster. The suggested divider values are 8, 6 and 5 ticks, for roughly 4x, 5.33x and 6.4x speed.

Every step toggles a polarity bit and drives a bipolar pulse onto the coil. The pulse has two phases. A short kick of reverse polarity comes first. A longer energise phase of forward polarity follows it. Then both lines return low. The forward direction alternates from one step to the next, as an alternating-field stepper needs.

The lengths of both phases are counted in units of a sub-tick enable input. The rate is chosen again on every tick, so a change of the switches applies to the very next tick. Ticks that arrive during a pulse are still counted.

Top module: `coil_step_driver`

## Requirements
- R1: After reset both coil lines are low, the tick counter is zero and the polarity bit is zero. The first step after reset therefore follows exactly the threshold count of the current mode.
- R2: When both switches are high (index 0), a step fires on the tick that brings the counter to 32 or more. From a cleared counter this is the 32nd tick.
- R3: The rate index has bit 0 = NOT mode1_ni and bit 1 = NOT mode2_ni. Index k (1..3) selects divider input k. A step fires on the tick that makes the incremented counter greater than or equal to that divider.
- R4: The rate is evaluated again on each tick. A counter that already exceeds the new threshold fires on the first tick after the switches change.
- R5: Each step clears the tick counter and inverts the polarity bit, so successive pulses alternate direction.
- R6: A step with polarity 1 drives B high and A low for KICK_LEN units. It then drives A high and B low for DRIVE_LEN units, and then both lines go low. Polarity 0 swaps the roles of A and B. The first step after reset has polarity 1, and the kick appears on the clock edge that takes the firing tick.
- R7: The pulse phases advance only on cycles where unit_en_i is high. While unit_en_i is low, the coil lines hold their current values.
- R8: coil_a_o and coil_b_o are never high together.
- R9: Ticks that arrive during a pulse increment the counter but never start a new step. The count they leave behind carries into the next threshold comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle base tick strobe |
| unit_en_i | input | 1 | Sub-tick enable that times the pulse phases |
| mode1_ni | input | 1 | Mode switch 1, active low (index bit 0) |
| mode2_ni | input | 1 | Mode switch 2, active low (index bit 1) |
| div1_i | input | CNT_W | Ticks per step for index 1 |
| div2_i | input | CNT_W | Ticks per step for index 2 |
| div3_i | input | CNT_W | Ticks per step for index 3 |
| coil_a_o | output | 1 | Coil line A drive |
| coil_b_o | output | 1 | Coil line B drive |

## Verification
The hardest case to reach is a counter that has filled up during a pulse: ticks landing while the sequencer is busy, whose count must carry into the next comparison. The bench reaches it by holding unit_en_i low right after a step, so the pulse stays frozen in its kick phase. It sends several ticks into that frozen pulse and confirms that the coil lines do not move. It then releases the enable, and the number of ticks needed for the next step shows how many were counted. A similar trick covers a mode change: the bench sets up a large count under the normal rate, then switches to a small divider.

// File: rtl/coil_step_pkg.sv
package coil_step_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_KICK  = 2'd1,
    PH_DRIVE = 2'd2
  } phase_e;
endpackage

// File: rtl/step_tick_counter.sv
module step_tick_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_next_o = cnt_q + CNT_W'(1);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_next_o;
  end
endmodule

// File: rtl/step_rate_select.sv
module step_rate_select #(
  parameter int CNT_W       = 8,
  parameter int NUM_FAST    = 3,
  parameter int NORMAL_LOG2 = 5,
  localparam int IDX_W      = $clog2(NUM_FAST + 1)
) (
  input  logic [IDX_W-1:0]          mode_idx_i,
  input  logic [NUM_FAST*CNT_W-1:0] div_flat_i,
  input  logic [CNT_W-1:0]          cnt_next_i,
  output logic                      hit_o
);
  logic [NUM_FAST:0] hit_vec;

  // normal rate: any bit at or above the threshold bit set
  assign hit_vec[0] = |cnt_next_i[CNT_W-1:NORMAL_LOG2];

  for (genvar k = 0; k < NUM_FAST; k++) begin : g_fast
    assign hit_vec[k+1] = cnt_next_i >= div_flat_i[k*CNT_W +: CNT_W];
  end

  assign hit_o = hit_vec[mode_idx_i];
endmodule

// File: rtl/step_pulse_seq.sv
module step_pulse_seq
  import coil_step_pkg::*;
#(
  parameter int KICK_LEN  = 6,
  parameter int DRIVE_LEN = 64,
  localparam int MAX_LEN  = (KICK_LEN > DRIVE_LEN) ? KICK_LEN : DRIVE_LEN,
  localparam int TMR_W    = $clog2(MAX_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic unit_en_i,
  output logic busy_o,
  output logic pol_o,
  output logic drive_a_o,
  output logic drive_b_o
);
  phase_e           phase_q;
  logic [TMR_W-1:0] tmr_q;
  logic             pol_q;
  logic             kick_end, drive_end;

  assign kick_end  = tmr_q == TMR_W'(KICK_LEN - 1);
  assign drive_end = tmr_q == TMR_W'(DRIVE_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
      pol_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (fire_i) begin
          phase_q <= PH_KICK;
          tmr_q   <= '0;
          pol_q   <= ~pol_q;
        end
        PH_KICK: if (unit_en_i) begin
          if (kick_end) begin
            phase_q <= PH_DRIVE;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + TMR_W'(1);
        end
        PH_DRIVE: if (unit_en_i) begin
          if (drive_end) begin
            phase_q <= PH_IDLE;
            tmr_q   <= '0;
          end else tmr_q <= tmr_q + TMR_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  logic kick_on, drive_on;
  assign kick_on   = phase_q == PH_KICK;
  assign drive_on  = phase_q == PH_DRIVE;
  assign busy_o    = phase_q != PH_IDLE;
  assign pol_o     = pol_q;
  // polarity 1: kick on B, energise on A
  assign drive_a_o = (kick_on & ~pol_q) | (drive_on & pol_q);
  assign drive_b_o = (kick_on & pol_q) | (drive_on & ~pol_q);
endmodule

// File: rtl/coil_step_driver.sv
module coil_step_driver #(
  parameter int CNT_W       = 8,
  parameter int NORMAL_LOG2 = 5,
  parameter int KICK_LEN    = 6,
  parameter int DRIVE_LEN   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             unit_en_i,
  input  logic             mode1_ni,
  input  logic             mode2_ni,
  input  logic [CNT_W-1:0] div1_i,
  input  logic [CNT_W-1:0] div2_i,
  input  logic [CNT_W-1:0] div3_i,
  output logic             coil_a_o,
  output logic             coil_b_o
);
  localparam int NUM_FAST = 3;

  logic [CNT_W-1:0]          cnt, cnt_next;
  logic [NUM_FAST*CNT_W-1:0] div_flat;
  logic [1:0]                mode_idx;
  logic                      hit, busy, pol, fire;

  assign mode_idx = {~mode2_ni, ~mode1_ni};
  assign div_flat = {div3_i, div2_i, div1_i};
  assign fire     = tick_i & ~busy & hit;

  step_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .clear_i    (fire),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next)
  );

  step_rate_select #(
    .CNT_W       (CNT_W),
    .NUM_FAST    (NUM_FAST),
    .NORMAL_LOG2 (NORMAL_LOG2)
  ) u_rate (
    .mode_idx_i (mode_idx),
    .div_flat_i (div_flat),
    .cnt_next_i (cnt_next),
    .hit_o      (hit)
  );

  step_pulse_seq #(
    .KICK_LEN  (KICK_LEN),
    .DRIVE_LEN (DRIVE_LEN)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .unit_en_i (unit_en_i),
    .busy_o    (busy),
    .pol_o     (pol),
    .drive_a_o (coil_a_o),
    .drive_b_o (coil_b_o)
  );
endmodule

// File: rtl/coil_step_driver_chk.sv
module coil_step_driver_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             unit_en_i,
  input logic             coil_a_o,
  input logic             coil_b_o,
  input logic             fire,
  input logic             busy,
  input logic             pol,
  input logic [CNT_W-1:0] cnt
);
  AST_COIL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(coil_a_o && coil_b_o)); // R8

  AST_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!coil_a_o && !coil_b_o)); // R6

  AST_FIRE_KICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (coil_a_o || coil_b_o)); // R6

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> cnt == '0); // R5

  AST_POL_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> pol != $past(pol)); // R5

  AST_BUSY_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && tick_i) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1))); // R9

  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt)); // R2

  AST_UNIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !unit_en_i) |=> $stable({coil_a_o, coil_b_o})); // R7
endmodule

bind coil_step_driver coil_step_driver_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .unit_en_i (unit_en_i),
  .coil_a_o  (coil_a_o),
  .coil_b_o  (coil_b_o),
  .fire      (fire),
  .busy      (busy),
  .pol       (pol),
  .cnt       (cnt)
);

// File: tb/sim_coil_step_driver.sv
module sim_coil_step_driver;
  localparam int CLK_PERIOD = 10;
  localparam int KICK       = 6;
  localparam int DRIVE      = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       unit_en = 1'b1;
  logic       m1_n = 1'b1, m2_n = 1'b1;
  logic [7:0] d1 = 8'd3, d2 = 8'd7, d3 = 8'd2;
  logic       coil_a, coil_b;

  int n_chk = 0, n_fail = 0;
  bit exp_pol = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coil_step_driver #(.CNT_W(8), .NORMAL_LOG2(5), .KICK_LEN(KICK), .DRIVE_LEN(DRIVE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .unit_en_i(unit_en),
    .mode1_ni(m1_n), .mode2_ni(m2_n), .div1_i(d1), .div2_i(d2), .div3_i(d3),
    .coil_a_o(coil_a), .coil_b_o(coil_b)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick_once(output bit fired);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    fired = coil_a | coil_b;
  endtask

  task automatic wait_idle();
    unit_en = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (!coil_a && !coil_b) break;
      @(negedge clk);
    end
  endtask

  task automatic ticks_to_step(output int n, output int kick_a);
    bit f;
    n = 0; kick_a = 0;
    for (int i = 1; i <= 300; i++) begin
      tick_once(f);
      if (f) begin n = i; kick_a = int'(coil_a); break; end
    end
    exp_pol = ~exp_pol;
    wait_idle();
  endtask

  // sample starts on the first kick cycle
  task automatic measure_pulse(input bit kick_on_a, input string req);
    int kn = 0, dn = 0, bad = 0;
    for (int i = 0; i < 200; i++) begin
      if (!coil_a && !coil_b) break;
      if (dn == 0 && (kick_on_a ? (coil_a && !coil_b) : (coil_b && !coil_a))) kn++;
      else if (kick_on_a ? (coil_b && !coil_a) : (coil_a && !coil_b)) dn++;
      else bad++;
      @(negedge clk);
    end
    chk(kn == KICK, req, "kick length", kn, KICK);
    chk(dn == DRIVE, req, "energise length", dn, DRIVE);
    chk(bad == 0 && !coil_a && !coil_b, req, "pattern/end off", bad, 0);
  endtask

  task automatic t_reset();
    int n, ka;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!coil_a && !coil_b, "R1", "lines low in reset", int'({coil_a, coil_b}), 0);
    rst_n = 1'b1;
    m1_n = 1'b1; m2_n = 1'b1;
    ticks_to_step(n, ka);
    chk(n == 32, "R2", "normal ticks to first step", n, 32);
    chk(ka == 0, "R6", "first kick on B", ka, 0);
  endtask

  task automatic t_shape();
    bit f;
    m1_n = 1'b1; m2_n = 1'b0; // index 2 -> d2
    m1_n = 1'b0; m2_n = 1'b0; // index 3 -> d3 = 2
    tick_once(f);
    chk(!f, "R3", "no step below divider", int'(f), 0);
    tick_once(f);
    chk(f, "R3", "step at divider", int'(f), 1);
    exp_pol = ~exp_pol;
    measure_pulse(1'b1, "R6");
    tick_once(f);
    tick_once(f);
    chk(f && coil_b, "R5", "alternated kick on B", int'(coil_b), 1);
    exp_pol = ~exp_pol;
    measure_pulse(1'b0, "R6");
  endtask

  task automatic t_modes();
    int n, ka;
    m1_n = 1'b0; m2_n = 1'b1;
    ticks_to_step(n, ka);
    chk(n == 3, "R3", "index 1 uses div1", n, 3);
    chk(ka == int'(!exp_pol), "R5", "polarity alternates", ka, int'(!exp_pol));
    m1_n = 1'b1; m2_n = 1'b0;
    ticks_to_step(n, ka);
    chk(n == 7, "R3", "index 2 uses div2", n, 7);
    chk(ka == int'(!exp_pol), "R5", "polarity alternates", ka, int'(!exp_pol));
    m1_n = 1'b0; m2_n = 1'b0;
    ticks_to_step(n, ka);
    chk(n == 2, "R3", "index 3 uses div3", n, 2);
  endtask

  task automatic t_switch();
    int quiet = 0, n, ka;
    bit f;
    m1_n = 1'b1; m2_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick_once(f);
      if (f) quiet++;
    end
    chk(quiet == 0, "R2", "no step before 32", quiet, 0);
    m1_n = 1'b0; m2_n = 1'b0;
    ticks_to_step(n, ka);
    chk(n == 1, "R4", "switch applies on next tick", n, 1);
  endtask

  task automatic t_gate();
    int n, ka, moved = 0;
    bit f, a0, b0;
    d3 = 8'd5;
    m1_n = 1'b0; m2_n = 1'b0;
    unit_en = 1'b0;
    n = 0;
    for (int i = 1; i <= 20; i++) begin
      tick_once(f);
      if (f) begin n = i; break; end
    end
    chk(n == 5, "R3", "ticks to step div 5", n, 5);
    exp_pol = ~exp_pol;
    a0 = coil_a; b0 = coil_b;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (coil_a != a0 || coil_b != b0) moved++;
    end
    chk(moved == 0, "R7", "frozen without unit enable", moved, 0);
    for (int i = 0; i < 3; i++) begin
      tick_once(f);
      if (coil_a != a0 || coil_b != b0) moved++;
    end
    chk(moved == 0, "R9", "ticks in pulse start no step", moved, 0);
    wait_idle();
    ticks_to_step(n, ka);
    chk(n == 2, "R9", "busy ticks were counted", n, 2);
  endtask

  initial begin
    t_reset();
    t_shape();
    t_modes();
    t_switch();
    t_gate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule